// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripheral sources and from external pins and drives two request lines toward a processor: a normal line and a fast line. Each normal source carries its own priority on one of eight levels, an enable bit, a trigger mode and an 8-bit vector. All of these are set through a small register interface. A qualifying edge on an edge-mode source sets a latch. A level-mode source is pending for as long as its input holds the active level.

The controller raises the normal line when a source is pending, enabled and eligible. A single read of the vector register returns that source's vector and number and also acknowledges it. The acknowledge clears the source's edge latch and marks its priority level as in service. While any level is in service, only sources of strictly higher priority can raise the normal line, so handlers can nest. Writing the end-of-interrupt register releases the most recently entered level. The fast line is driven only by the dedicated fast input and its own enable bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, nirq_o and fiq_o are 0, the enable register (address N_SRC) reads 0, and every source config reads 0 (priority 0, high level, vector 0).
- R2: A source whose bit in the enable register is 0 never raises nirq_o. It still shows as 1 in the raw pending register at address N_SRC+3, where bit i is source i.
- R3: Among eligible sources, the one with the numerically largest priority (config bits [2:0], 0 to 7) wins. A tie at the same priority goes to the lowest source index. Sources 0 to N_INT-1 are internal and N_INT upward are external.
- R4: fiq_o equals fast_irq_i ANDed with enable bit N_SRC, one clock later. fast_irq_i never affects nirq_o or the vector register.
- R5: Reading address N_SRC+1 returns bit 31 = valid, bits [23:16] = winning source index and bits [7:0] = its vector (config bits [15:8]). With no eligible source it returns 0 and changes no state.
- R6: For internal sources, config bit 3 selects the trigger: 0 is active-high level and 1 is rising edge. Config bit 4 has no effect on them.
- R7: For external sources, config bits [4:3] select the trigger: 00 is high level, 01 is low level, 10 is rising edge and 11 is falling edge.
- R8: A valid vector read clears the winner's edge latch and marks its priority as in service. While any level is in service, only a source with a strictly higher priority than the highest in-service level raises nirq_o.
- R9: A write to address N_SRC+2 releases only the highest in-service level. The write has no effect when no level is in service.
- R10: An edge-mode source stays pending after its input returns to idle, until the source is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_src_i | input | N_INT | Internal peripheral request inputs |
| ext_src_i | input | N_EXT | External pin request inputs |
| fast_irq_i | input | 1 | Dedicated fast request input |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (vector read acknowledges) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle rd_en_i is high |
| nirq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The assertions assume that all request inputs are synchronous to clk and that at most one register access is presented in a cycle. Under that assumption, a push and a release of the in-service mask never coincide. The bench drives every input at the falling edge, so the inputs are steady at each rising edge. It issues a single read or write per transfer and then returns both strobes low, which keeps the stimulus within these assumptions. Edge-mode stimuli hold each level for at least one full clock, so the registered previous sample sees every transition.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PRIO_W  = 3;
    localparam int NUM_LVL = 1 << PRIO_W;
    localparam int VEC_W   = 8;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_LOW  = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [2:0]        spare;
        trig_e             trig;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/pic_source.sv
module pic_source
    import pic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_i,
    input  trig_e mode_i,
    input  logic  ack_i,
    output logic  pend_o
);
    typedef struct packed {
        logic prev;
        logic latch;
    } cond_t;

    cond_t q, d;
    logic  is_edge, edge_hit;

    always_comb begin
        d        = q;
        is_edge  = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL);
        edge_hit = ((mode_i == TRIG_RISE) && src_i && !q.prev) ||
                   ((mode_i == TRIG_FALL) && !src_i && q.prev);
        d.prev   = src_i;
        if (!is_edge)      d.latch = 1'b0;
        else if (edge_hit) d.latch = 1'b1;
        else if (ack_i)    d.latch = 1'b0;
        if (is_edge)                  pend_o = q.latch;
        else if (mode_i == TRIG_LOW)  pend_o = !src_i;
        else                          pend_o = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: an acknowledge without a fresh edge leaves the latch empty
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !edge_hit) |=> !q.latch);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N_SRC = 7,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]             req_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic                         busy_i,
    input  logic [PRIO_W-1:0]            level_i,
    output logic                         win_valid_o,
    output logic [IDX_W-1:0]             win_idx_o,
    output logic [PRIO_W-1:0]            win_prio_o
);
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i] && (!busy_i || prio_i[i] > level_i) &&
                (!win_valid_o || prio_i[i] > win_prio_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/pic_nest.sv
module pic_nest
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_lvl_i,
    input  logic              pop_i,
    output logic              busy_o,
    output logic [PRIO_W-1:0] level_o
);
    typedef struct packed {
        logic [NUM_LVL-1:0] isr;
    } nest_t;

    nest_t q, d;

    always_comb begin
        d       = q;
        busy_o  = |q.isr;
        level_o = '0;
        for (int l = 0; l < NUM_LVL; l++)
            if (q.isr[l]) level_o = PRIO_W'(l);
        if (push_i)
            d.isr[push_lvl_i] = 1'b1;
        else if (pop_i && busy_o)
            d.isr[level_o] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a new level only ever enters above the current one
    assert_push_above_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && busy_o) |-> (push_lvl_i > level_o));

    // R9: a release removes exactly one level
    assert_pop_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && busy_o) |=> ($countones(q.isr) + 1 == $past($countones(q.isr))));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_INT  = 4,
    parameter int N_EXT  = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_INT-1:0]  int_src_i,
    input  logic [N_EXT-1:0]  ext_src_i,
    input  logic              fast_irq_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output logic [31:0]       rdata_o,
    output logic              nirq_o,
    output logic              fiq_o
);
    localparam int N_SRC    = N_INT + N_EXT;
    localparam int IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int REG_ENA  = N_SRC;
    localparam int REG_VEC  = N_SRC + 1;
    localparam int REG_EOI  = N_SRC + 2;
    localparam int REG_PEND = N_SRC + 3;

    typedef struct packed {
        src_cfg_t [N_SRC-1:0] cfg;
        logic [N_SRC:0]       ena;
        logic                 fast;
        logic                 irq;
    } ctrl_t;

    ctrl_t q, d;

    logic [N_SRC-1:0]             raw_src, pend, ack_vec;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_vec;
    trig_e                        mode_vec [N_SRC];
    logic                         win_valid, busy, ack, pop;
    logic [IDX_W-1:0]             win_idx;
    logic [PRIO_W-1:0]            win_prio, level;
    logic [VEC_W-1:0]             win_vec;

    assign raw_src = {ext_src_i, int_src_i};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g < N_INT) begin : g_int
            assign mode_vec[g] = q.cfg[g].trig[0] ? TRIG_RISE : TRIG_HIGH;
        end else begin : g_ext
            assign mode_vec[g] = q.cfg[g].trig;
        end
        assign prio_vec[g] = q.cfg[g].prio;
        assign ack_vec[g]  = ack && (win_idx == IDX_W'(g));

        pic_source u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (raw_src[g]),
            .mode_i (mode_vec[g]),
            .ack_i  (ack_vec[g]),
            .pend_o (pend[g])
        );
    end

    pic_arbiter #(.N_SRC(N_SRC)) u_arb (
        .req_i       (pend & q.ena[N_SRC-1:0]),
        .prio_i      (prio_vec),
        .busy_i      (busy),
        .level_i     (level),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_prio_o  (win_prio)
    );

    pic_nest u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack),
        .push_lvl_i (win_prio),
        .pop_i      (pop),
        .busy_o     (busy),
        .level_o    (level)
    );

    always_comb begin
        d      = q;
        d.fast = fast_irq_i & q.ena[N_SRC];
        d.irq  = win_valid;
        pop    = 1'b0;
        ack    = rd_en_i && (addr_i == ADDR_W'(REG_VEC)) && win_valid;
        if (wr_en_i) begin
            for (int i = 0; i < N_SRC; i++)
                if (addr_i == ADDR_W'(i)) d.cfg[i] = src_cfg_t'(wdata_i);
            if (addr_i == ADDR_W'(REG_ENA)) d.ena = wdata_i[N_SRC:0];
            if (addr_i == ADDR_W'(REG_EOI)) pop = 1'b1;
        end
    end

    always_comb begin
        win_vec = '0;
        for (int i = 0; i < N_SRC; i++)
            if (win_idx == IDX_W'(i)) win_vec = q.cfg[i].vector;
        rdata_o = '0;
        for (int i = 0; i < N_SRC; i++)
            if (addr_i == ADDR_W'(i)) rdata_o[CFG_W-1:0] = q.cfg[i];
        if (addr_i == ADDR_W'(REG_ENA)) rdata_o[N_SRC:0] = q.ena;
        if (addr_i == ADDR_W'(REG_PEND)) rdata_o[N_SRC-1:0] = pend;
        if (addr_i == ADDR_W'(REG_VEC) && win_valid) begin
            rdata_o[31]            = 1'b1;
            rdata_o[16 +: IDX_W]   = win_idx;
            rdata_o[VEC_W-1:0]     = win_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign nirq_o = q.irq;
    assign fiq_o  = q.fast;

    // R2: the arbiter only ever selects an enabled source
    assert_win_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> q.ena[win_idx]);

    // R4: the fast line needs the fast input one cycle earlier
    assert_fiq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(fast_irq_i));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int PERIOD   = 10;
    localparam int N_INT    = 4;
    localparam int N_EXT    = 3;
    localparam int N_SRC    = N_INT + N_EXT;
    localparam int ADDR_W   = 4;
    localparam int REG_ENA  = N_SRC;
    localparam int REG_VEC  = N_SRC + 1;
    localparam int REG_EOI  = N_SRC + 2;
    localparam int REG_PEND = N_SRC + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_INT-1:0]  int_src = '0;
    logic [N_EXT-1:0]  ext_src = '0;
    logic              fast = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              nirq, fiq;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];

    prio_irq_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .int_src_i(int_src), .ext_src_i(ext_src),
        .fast_irq_i(fast), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .nirq_o(nirq), .fiq_o(fiq)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        #(PERIOD/4) v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cfg(input int s, input logic [2:0] p, input logic [1:0] t, input logic [7:0] v);
        wr(s, {v, 3'b000, t, p});
    endtask

    // driver: pushes the expected vector word, then performs the acknowledging read
    task automatic read_vec(input logic ok, input int idx, input logic [7:0] v);
        logic [31:0] dummy;
        exp_q.push_back(ok ? {1'b1, 7'b0, 8'(idx), 8'b0, v} : 32'h0);
        rd(REG_VEC, dummy);
    endtask

    // monitor: compares each vector read with the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            if (rd_en && addr == ADDR_W'(REG_VEC)) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5: unexpected vector read actual=%h expected=none", rdata);
                end else begin
                    check("R5 vector word", rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 nirq", 32'(nirq), 0);
        check("R1 fiq", 32'(fiq), 0);
        rd(REG_ENA, v);  check("R1 enable", v, 0);
        rd(3, v);        check("R1 config", v, 0);
        read_vec(1'b0, 0, 8'h00);

        // R2 masking
        cfg(0, 3'd1, 2'b00, 8'h10);
        int_src[0] = 1'b1;
        idle(3); check("R2 masked nirq", 32'(nirq), 0);
        rd(REG_PEND, v); check("R2 raw pending", v, 32'h1);
        wr(REG_ENA, 16'h0001);
        idle(3); check("R2 enabled nirq", 32'(nirq), 1);

        // R5/R8/R9 acknowledge and release
        read_vec(1'b1, 0, 8'h10);
        idle(3); check("R8 same source blocked", 32'(nirq), 0);
        wr(REG_EOI, 0);
        idle(3); check("R9 release reopens", 32'(nirq), 1);
        read_vec(1'b1, 0, 8'h10);
        int_src[0] = 1'b0;
        wr(REG_EOI, 0);
        idle(3); check("R9 idle after release", 32'(nirq), 0);

        // R3 priority and ties, R8 nesting
        cfg(1, 3'd5, 2'b00, 8'h21);
        cfg(2, 3'd5, 2'b00, 8'h22);
        cfg(3, 3'd3, 2'b00, 8'h23);
        wr(REG_ENA, 16'h000F);
        int_src[3:1] = 3'b111;
        idle(3); check("R3 nirq", 32'(nirq), 1);
        read_vec(1'b1, 1, 8'h21);                 // R3 tie to lowest index
        idle(3); check("R8 equal priority blocked", 32'(nirq), 0);
        int_src[1] = 1'b0;
        wr(REG_EOI, 0);
        read_vec(1'b1, 2, 8'h22);
        int_src[2] = 1'b0;
        wr(REG_EOI, 0);
        read_vec(1'b1, 3, 8'h23);                 // R3 lower level served last
        int_src[0] = 1'b1;
        idle(3); check("R8 lower priority blocked", 32'(nirq), 0);
        int_src[0] = 1'b0;
        int_src[1] = 1'b1;
        idle(3); check("R8 higher priority nests", 32'(nirq), 1);
        read_vec(1'b1, 1, 8'h21);
        int_src[1] = 1'b0;
        wr(REG_EOI, 0);
        idle(3); check("R9 only top level released", 32'(nirq), 0);
        int_src[3] = 1'b0;
        wr(REG_EOI, 0);
        idle(3); check("R9 all released", 32'(nirq), 0);

        // R6/R10 internal edge
        cfg(0, 3'd2, 2'b01, 8'h30);
        @(negedge clk) int_src[0] = 1'b1;
        @(negedge clk) int_src[0] = 1'b0;
        idle(3); check("R10 edge held", 32'(nirq), 1);
        read_vec(1'b1, 0, 8'h30);
        idle(3); check("R8 acked edge", 32'(nirq), 0);
        wr(REG_EOI, 0);
        idle(3); check("R8 latch cleared", 32'(nirq), 0);
        rd(REG_PEND, v); check("R8 pending empty", v, 0);
        cfg(0, 3'd2, 2'b10, 8'h31);               // R6 bit 4 ignored: level
        int_src[0] = 1'b1;
        idle(3); check("R6 level high", 32'(nirq), 1);
        int_src[0] = 1'b0;
        idle(3); check("R6 level released", 32'(nirq), 0);

        // R7 external modes
        ext_src[0] = 1'b1;
        cfg(4, 3'd4, 2'b01, 8'h44);
        wr(REG_ENA, 16'h0070);
        idle(3); check("R7 low level idle", 32'(nirq), 0);
        ext_src[0] = 1'b0;
        idle(3); check("R7 low level active", 32'(nirq), 1);
        read_vec(1'b1, 4, 8'h44);
        ext_src[0] = 1'b1;
        wr(REG_EOI, 0);
        idle(3); check("R7 low level done", 32'(nirq), 0);
        ext_src[1] = 1'b1;
        cfg(5, 3'd4, 2'b11, 8'h55);
        idle(2);
        ext_src[1] = 1'b0;
        idle(3); check("R7 falling edge", 32'(nirq), 1);
        read_vec(1'b1, 5, 8'h55);
        wr(REG_EOI, 0);
        idle(3); check("R7 falling consumed", 32'(nirq), 0);
        cfg(6, 3'd4, 2'b10, 8'h66);
        ext_src[2] = 1'b1;
        idle(3); check("R7 rising edge", 32'(nirq), 1);
        read_vec(1'b1, 6, 8'h66);
        wr(REG_EOI, 0);
        idle(3); check("R7 rising consumed while high", 32'(nirq), 0);
        ext_src[2] = 1'b0;
        cfg(4, 3'd4, 2'b00, 8'h47);
        idle(3); check("R7 high level", 32'(nirq), 1);
        read_vec(1'b1, 4, 8'h47);
        ext_src[0] = 1'b0;
        wr(REG_EOI, 0);
        idle(3); check("R7 high level done", 32'(nirq), 0);

        // R4 fast line
        fast = 1'b1;
        idle(3); check("R4 fast masked", 32'(fiq), 0);
        wr(REG_ENA, 16'h00F0);
        idle(3); check("R4 fast on", 32'(fiq), 1);
        check("R4 nirq untouched", 32'(nirq), 0);
        read_vec(1'b0, 0, 8'h00);                 // R4 fast never in vector
        fast = 1'b0;
        idle(3); check("R4 fast off", 32'(fiq), 0);

        // R9 release with nothing in service, R5 spurious read
        wr(REG_EOI, 0);
        cfg(1, 3'd6, 2'b00, 8'h61);
        wr(REG_ENA, 16'h0002);
        int_src[1] = 1'b1;
        idle(3); check("R9 empty release harmless", 32'(nirq), 1);
        read_vec(1'b1, 1, 8'h61);
        int_src[1] = 1'b0;
        wr(REG_EOI, 0);
        idle(3); check("R9 final idle", 32'(nirq), 0);

        idle(2);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R5: reads missing actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule